// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block collects serial words from a data line. The words are timed by a receive bit clock and aligned by a receive frame-sync input. The bit clock is an ordinary input that is sampled in the system clock domain. Each high-to-low transition of the bit clock is one bit event. At each bit event the frame-sync and data inputs are sampled. Words arrive most significant bit first.

A two-bit setting chooses how many bit events separate an accepted frame-sync from the first data bit: 0, 1 or 2. The setting value 3 behaves as 2. A frame-sync may come back-to-back with the frame in progress, at the earliest point that still lets the new frame's first bit follow the old frame's last bit. That earliest point depends on the delay setting. A frame-sync that comes before it is ignored for framing and raises a sticky frame-sync-error flag.

Finished words enter a small buffer. A host reads the buffer through a one-cycle read strobe. A read from an empty buffer still returns a value (zero), leaves the buffer untouched, and raises a sticky underflow flag. When enabled, the underflow flag pulls an active-low interrupt.

The framing controller has four states:
- `S_IDLE`: no frame in progress.
- `S_DELAY`: a frame-sync has been accepted and the delay is counting down.
- `S_SHIFT`: data bits are being received.
- `S_SHIFT_ARMED`: bits are still being received, and the next frame-sync has already been accepted.

The transitions are:
- `S_IDLE` to `S_SHIFT`: frame-sync with delay 0.
- `S_IDLE` to `S_DELAY`: frame-sync with delay 1 or 2.
- `S_DELAY` to `S_SHIFT`: the first data bit arrives.
- `S_SHIFT` to `S_IDLE`: the last bit arrives with no frame-sync.
- `S_SHIFT` to `S_DELAY`: the last bit arrives together with a frame-sync.
- `S_SHIFT` to `S_SHIFT_ARMED`: a frame-sync on the second-to-last bit with delay 2.
- `S_SHIFT_ARMED` to `S_DELAY`: the last bit arrives.
- Any state to `S_IDLE`: `rx_hold`.

Top module: `framed_rx`

## Requirements
- R1: Bits are taken at the bit events, which are the system-clock edges where `rx_bclk` was 1 at the previous edge and is 0 now. Bits are assembled most significant bit first into WORD_W-bit words.
- R2: With `delay_sel` = d (value 3 acting as 2), the first data bit is the bit event d events after the event that carried the accepted frame-sync.
- R3: A frame-sync is legal when no frame is active and none is pending. It is also legal during an active frame when at most d bits of that frame remain, counting the current bit. A frame-sync in this late window starts the next frame with no gap.
- R4: A frame-sync is early when it comes while a frame is pending, or while more than d bits of the active frame remain. An early frame-sync does not change framing and sets `fse_flag`, which stays set.
- R5: `rx_ready` is 1 when at least one word is buffered. Words are read out in arrival order.
- R6: When the buffer holds DEPTH words and no read is made in that cycle, a newly completed word is discarded.
- R7: `rd_en` on an empty buffer loads `rd_data` with zero, leaves the buffer unchanged and sets `unf_flag`, which stays set.
- R8: A 1 on `unf_clr` or `fse_clr` clears the matching flag. If a set and a clear happen in the same cycle, the set wins.
- R9: `irq_n` is 0 exactly when `unf_flag` and `unf_irq_en` are both 1.
- R10: While `rx_hold` is 1, the partial frame, any pending frame and all buffered words are cleared, and reads are ignored. `unf_flag` and `fse_flag` are kept.
- R11: `rd_data` takes the oldest word on the clock edge where `rd_en` is sampled, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| rx_hold | input | 1 | Holds the receiver in reset; the flags are kept |
| rx_bclk | input | 1 | Receive bit clock; a falling transition is a bit event |
| rx_fs | input | 1 | Receive frame-sync, sampled at bit events |
| rx_data | input | 1 | Serial data, sampled at bit events |
| delay_sel | input | 2 | Delay from frame-sync to first bit: 0, 1, 2 (3 acts as 2) |
| rd_en | input | 1 | Read strobe for the receive buffer |
| rd_data | output | WORD_W | Last word read (zero after an empty read) |
| rx_ready | output | 1 | At least one word is buffered |
| unf_clr | input | 1 | Write-one clear for the underflow flag |
| fse_clr | input | 1 | Write-one clear for the frame-sync-error flag |
| unf_irq_en | input | 1 | Lets the underflow flag drive the interrupt |
| unf_flag | output | 1 | Sticky underflow flag |
| fse_flag | output | 1 | Sticky early-frame-sync flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench streams words back to back at the earliest legal frame-sync for each delay setting. A design that placed the legal window one bit off would either flag these frame-syncs as errors or drop a bit. Frame-syncs are also injected one step too early, in the middle of a word and on the last bit with zero delay. A design that honoured them would corrupt the word in progress, and one that ignored them silently would leave the error flag clear. The buffer is overfilled and read empty. A wrong design would overwrite the oldest word, return stale data, or move its pointers on an empty read. A set and a clear of the underflow flag are made to collide, and `rx_hold` is applied in the middle of a frame. A design that resumed the stale partial frame or wiped the flags would show it in the next word or in the flag outputs.

// File: rtl/framed_rx_pkg.sv
package framed_rx_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DELAY,
        S_SHIFT,
        S_SHIFT_ARMED
    } rx_state_e;

    // Delay setting 3 behaves as 2.
    function automatic logic [1:0] eff_delay(input logic [1:0] sel);
        return (sel == 2'd3) ? 2'd2 : sel;
    endfunction

endpackage

// File: rtl/framed_rx_deser.sv
module framed_rx_deser
    import framed_rx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              bclk,
    input  logic              fs,
    input  logic              din,
    input  logic [1:0]        dly_sel,
    output logic              word_push,
    output logic [WORD_W-1:0] word,
    output logic              fs_err
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    rx_state_e         state, nxt_state;
    logic [CNT_W-1:0]  bit_cnt, nxt_bit_cnt;
    logic [1:0]        dly_cnt, nxt_dly;
    logic [WORD_W-1:0] sreg, nxt_sreg;
    logic              bclk_q;
    logic              evt, fs_legal, fs_take, last_bit;
    logic [1:0]        d;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        d        = eff_delay(dly_sel);
        evt      = bclk_q & ~bclk;
        last_bit = (32'(bit_cnt) == WORD_W - 1);
        shifted  = {sreg[WORD_W-2:0], din};
        unique case (state)
            S_IDLE:        fs_legal = 1'b1;
            S_DELAY:       fs_legal = 1'b0;
            S_SHIFT:       fs_legal = (d != 2'd0) && (32'(bit_cnt) + 32'(d) >= WORD_W);
            S_SHIFT_ARMED: fs_legal = 1'b0;
            default:       fs_legal = 1'b0;
        endcase
        fs_take = evt & fs & fs_legal;
    end

    // Bit-clock edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk;
    end

    // Next-state logic
    always_comb begin
        nxt_state   = state;
        nxt_bit_cnt = bit_cnt;
        nxt_dly     = dly_cnt;
        nxt_sreg    = sreg;
        if (evt) begin
            unique case (state)
                S_IDLE: begin
                    if (fs_take) begin
                        if (d == 2'd0) begin
                            nxt_sreg    = shifted;
                            nxt_bit_cnt = CNT_W'(1);
                            nxt_state   = S_SHIFT;
                        end else begin
                            nxt_dly   = d - 2'd1;
                            nxt_state = S_DELAY;
                        end
                    end
                end
                S_DELAY: begin
                    if (dly_cnt == 2'd0) begin
                        nxt_sreg    = shifted;
                        nxt_bit_cnt = CNT_W'(1);
                        nxt_state   = S_SHIFT;
                    end else begin
                        nxt_dly = dly_cnt - 2'd1;
                    end
                end
                S_SHIFT: begin
                    nxt_sreg = shifted;
                    if (last_bit) begin
                        nxt_bit_cnt = '0;
                        if (fs_take) begin
                            nxt_dly   = d - 2'd1;
                            nxt_state = S_DELAY;
                        end else begin
                            nxt_state = S_IDLE;
                        end
                    end else begin
                        nxt_bit_cnt = bit_cnt + CNT_W'(1);
                        if (fs_take) begin
                            nxt_dly   = d - 2'd1;
                            nxt_state = S_SHIFT_ARMED;
                        end
                    end
                end
                S_SHIFT_ARMED: begin
                    nxt_sreg = shifted;
                    if (dly_cnt != 2'd0) nxt_dly = dly_cnt - 2'd1;
                    if (last_bit) begin
                        nxt_bit_cnt = '0;
                        nxt_state   = S_DELAY;
                    end else begin
                        nxt_bit_cnt = bit_cnt + CNT_W'(1);
                    end
                end
                default: nxt_state = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            bit_cnt <= '0;
            dly_cnt <= '0;
            sreg    <= '0;
        end else if (hold) begin
            state   <= S_IDLE;
            bit_cnt <= '0;
            dly_cnt <= '0;
            sreg    <= '0;
        end else begin
            state   <= nxt_state;
            bit_cnt <= nxt_bit_cnt;
            dly_cnt <= nxt_dly;
            sreg    <= nxt_sreg;
        end
    end

    // Outputs
    always_comb begin
        word_push = evt & ~hold & last_bit &
                    ((state == S_SHIFT) || (state == S_SHIFT_ARMED));
        word      = shifted;
        fs_err    = evt & fs & ~fs_legal & ~hold;
    end

    // R2: the delay countdown moves only on bit events
    assert_delay_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DELAY && !evt && !hold) |=> (state == S_DELAY));

    // R4: an early frame-sync in mid-word leaves the frame running
    assert_early_fs_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT && fs_err && !last_bit && !hold) |=> (state == S_SHIFT));

    // R3: the next frame is armed only for the final bit of the current one
    assert_armed_last_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT_ARMED) |-> last_bit);

endmodule

// File: rtl/framed_rx_fifo.sv
module framed_rx_fifo #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop_req,
    output logic [WORD_W-1:0] rdata,
    output logic              ready,
    output logic              empty_rd
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              full, is_empty, pop, wr;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        full     = (count == CNT_W'(DEPTH));
        is_empty = (count == '0);
        pop      = pop_req & ~is_empty;
        wr       = push & (~full | pop);
        empty_rd = pop_req & is_empty;
        ready    = ~is_empty;
    end

    always_ff @(posedge clk) begin
        if (wr) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr)  wr_ptr <= ptr_inc(wr_ptr);
            if (pop) rd_ptr <= ptr_inc(rd_ptr);
            unique case ({wr, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rdata <= '0;
        else if (pop)      rdata <= mem[rd_ptr];
        else if (empty_rd) rdata <= '0;
    end

    // R6: a full buffer without a read stays full and drops the word
    assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop_req && !flush) |=> full);

    // R7: an empty read leaves the buffer empty
    assert_empty_read_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_rd && !push) |=> is_empty);

endmodule

// File: rtl/framed_rx_status.sv
module framed_rx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_unf,
    input  logic clr_unf,
    input  logic set_fse,
    input  logic clr_fse,
    input  logic irq_en,
    output logic unf,
    output logic fse,
    output logic irq_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unf <= 1'b0;
            fse <= 1'b0;
        end else begin
            if (set_unf)      unf <= 1'b1;
            else if (clr_unf) unf <= 1'b0;
            if (set_fse)      fse <= 1'b1;
            else if (clr_fse) fse <= 1'b0;
        end
    end

    always_comb irq_n = ~(unf & irq_en);

    // R8: the flag stays set until a clear
    assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (unf && !clr_unf) |=> unf);

    // R8: a set wins over a clear in the same cycle
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_fse && clr_fse) |=> fse);

endmodule

// File: rtl/framed_rx.sv
module framed_rx #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_hold,
    input  logic              rx_bclk,
    input  logic              rx_fs,
    input  logic              rx_data,
    input  logic [1:0]        delay_sel,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rx_ready,
    input  logic              unf_clr,
    input  logic              fse_clr,
    input  logic              unf_irq_en,
    output logic              unf_flag,
    output logic              fse_flag,
    output logic              irq_n
);
    logic              word_push, fs_err, empty_rd, pop_req;
    logic [WORD_W-1:0] word;

    always_comb pop_req = rd_en & ~rx_hold;

    framed_rx_deser #(.WORD_W(WORD_W)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (rx_hold),
        .bclk      (rx_bclk),
        .fs        (rx_fs),
        .din       (rx_data),
        .dly_sel   (delay_sel),
        .word_push (word_push),
        .word      (word),
        .fs_err    (fs_err)
    );

    framed_rx_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (rx_hold),
        .push     (word_push),
        .wdata    (word),
        .pop_req  (pop_req),
        .rdata    (rd_data),
        .ready    (rx_ready),
        .empty_rd (empty_rd)
    );

    framed_rx_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_unf (empty_rd),
        .clr_unf (unf_clr),
        .set_fse (fs_err),
        .clr_fse (fse_clr),
        .irq_en  (unf_irq_en),
        .unf     (unf_flag),
        .fse     (fse_flag),
        .irq_n   (irq_n)
    );

    // R9: an enabled underflow flag holds the interrupt low
    assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_flag && unf_irq_en) |-> !irq_n);

    // R10: a hold leaves no buffered words
    assert_hold_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_hold |=> !rx_ready);

endmodule

// File: tb/framed_rx_test.sv
`timescale 1ns/1ps
module framed_rx_test;
    localparam int W = 8;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_hold = 1'b0, rx_bclk = 1'b0, rx_fs = 1'b0, rx_data = 1'b0;
    logic [1:0] delay_sel = 2'd0;
    logic rd_en = 1'b0, unf_clr = 1'b0, fse_clr = 1'b0, unf_irq_en = 1'b0;
    logic [W-1:0] rd_data;
    logic rx_ready, unf_flag, fse_flag, irq_n;

    int tests = 0, fails = 0;
    bit live = 0;

    always #2.5 clk = ~clk;

    framed_rx #(.WORD_W(W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .rx_hold(rx_hold), .rx_bclk(rx_bclk),
        .rx_fs(rx_fs), .rx_data(rx_data), .delay_sel(delay_sel),
        .rd_en(rd_en), .rd_data(rd_data), .rx_ready(rx_ready),
        .unf_clr(unf_clr), .fse_clr(fse_clr), .unf_irq_en(unf_irq_en),
        .unf_flag(unf_flag), .fse_flag(fse_flag), .irq_n(irq_n)
    );

    // Behavioural reference model
    int m_left = 0, m_wait = -1;
    logic [W-1:0] m_acc = '0, m_rd = '0;
    logic [W-1:0] m_q[$];
    bit m_unf = 0, m_fse = 0, m_prevb = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_wait = -1; m_acc = '0; m_rd = '0;
            m_q.delete(); m_unf = 0; m_fse = 0; m_prevb = 0;
        end else begin
            int d;
            bit ev, s_unf, s_fse, legal, now;
            d = (delay_sel == 2'd3) ? 2 : int'(delay_sel);
            ev = m_prevb && !rx_bclk;
            m_prevb = rx_bclk;
            s_unf = 0; s_fse = 0;
            if (rx_hold) begin
                m_left = 0; m_wait = -1; m_q.delete();
            end else begin
                if (rd_en) begin
                    if (m_q.size() > 0) m_rd = m_q.pop_front();
                    else begin m_rd = '0; s_unf = 1; end
                end
                if (ev) begin
                    legal = (m_wait < 0) && (m_left <= d);
                    now = rx_fs && legal && d == 0;
                    if (rx_fs && !legal) s_fse = 1;
                    if (now || (m_left == 0 && m_wait == 0)) begin
                        m_acc = W'(rx_data); m_left = W - 1; m_wait = -1;
                    end else if (m_left > 0) begin
                        m_acc = {m_acc[W-2:0], rx_data};
                        m_left--;
                        if (m_left == 0 && m_q.size() < DEPTH) m_q.push_back(m_acc);
                        if (m_wait > 0) m_wait--;
                    end else if (m_wait > 0) m_wait--;
                    if (rx_fs && legal && d > 0) m_wait = d - 1;
                end
            end
            if (unf_clr) m_unf = 0;
            if (s_unf) m_unf = 1;
            if (fse_clr) m_fse = 0;
            if (s_fse) m_fse = 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk("R5 rx_ready", 32'(rx_ready), 32'(m_q.size() > 0));
            chk("R11 rd_data", 32'(rd_data), 32'(m_rd));
            chk("R7 unf_flag", 32'(unf_flag), 32'(m_unf));
            chk("R4 fse_flag", 32'(fse_flag), 32'(m_fse));
            chk("R9 irq_n", 32'(irq_n), 32'(!(m_unf && unf_irq_en)));
        end
    end

    task automatic send_bit(input logic f, input logic b);
        @(negedge clk);
        rx_bclk = 1'b1; rx_fs = f; rx_data = b;
        repeat (2) @(negedge clk);
        rx_bclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Words sent with frame-syncs placed delay d ahead of each first bit
    task automatic run_words(input int d, input logic [W-1:0] w[$], input int gap);
        int n, len;
        n = w.size();
        len = d + n * (W + gap);
        for (int t = 0; t < len; t++) begin
            logic f, b;
            f = 1'b0; b = 1'b0;
            for (int k = 0; k < n; k++) begin
                int t0;
                t0 = d + k * (W + gap);
                if (t == t0 - d) f = 1'b1;
                if (t >= t0 && t < t0 + W) b = w[k][W-1-(t-t0)];
            end
            send_bit(f, b);
        end
        send_bit(1'b0, 1'b0);
    endtask

    task automatic do_read();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse_unf_clr();
        @(negedge clk); unf_clr = 1'b1;
        @(negedge clk); unf_clr = 1'b0;
    endtask

    task automatic pulse_fse_clr();
        @(negedge clk); fse_clr = 1'b1;
        @(negedge clk); fse_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1;
        @(negedge clk);
        chk("R5 reset rx_ready", 32'(rx_ready), 0);
        chk("R7 reset unf_flag", 32'(unf_flag), 0);
        chk("R4 reset fse_flag", 32'(fse_flag), 0);
        chk("R9 reset irq_n", 32'(irq_n), 1);

        // R1 R3: zero delay, back to back
        delay_sel = 2'd0;
        run_words(0, '{8'hA5, 8'h3C}, 0);
        chk("R5 ready after words", 32'(rx_ready), 1);
        do_read(); chk("R1 word0 delay0", 32'(rd_data), 32'hA5);
        do_read(); chk("R3 word1 delay0", 32'(rd_data), 32'h3C);
        chk("R4 no error on legal fs", 32'(fse_flag), 0);

        // R2 R3: one-bit delay, back to back
        delay_sel = 2'd1;
        run_words(1, '{8'h81, 8'h7E}, 0);
        do_read(); chk("R2 word0 delay1", 32'(rd_data), 32'h81);
        do_read(); chk("R3 word1 delay1", 32'(rd_data), 32'h7E);

        // R2 R3: two-bit delay, back to back
        delay_sel = 2'd2;
        run_words(2, '{8'hC3, 8'h5A}, 0);
        do_read(); chk("R2 word0 delay2", 32'(rd_data), 32'hC3);
        do_read(); chk("R3 word1 delay2", 32'(rd_data), 32'h5A);
        chk("R4 no error at earliest fs", 32'(fse_flag), 0);

        // R2: setting 3 acts as 2
        delay_sel = 2'd3;
        run_words(2, '{8'h96}, 2);
        do_read(); chk("R2 sel3 word", 32'(rd_data), 32'h96);

        // R4: early frame-sync in mid-word, delay 1
        delay_sel = 2'd1;
        send_bit(1'b1, 1'b0);
        for (int i = 0; i < W; i++) send_bit(i == 3, (8'hF0 >> (W-1-i)) & 1'b1);
        send_bit(1'b0, 1'b0);
        chk("R4 fse set", 32'(fse_flag), 1);
        do_read(); chk("R4 word unaffected", 32'(rd_data), 32'hF0);
        pulse_fse_clr();
        chk("R8 fse cleared", 32'(fse_flag), 0);

        // R4: zero delay, frame-sync on the last bit is early
        delay_sel = 2'd0;
        for (int i = 0; i < W; i++) send_bit(i == 0 || i == W-1, (8'h69 >> (W-1-i)) & 1'b1);
        send_bit(1'b0, 1'b0);
        chk("R4 fse last bit delay0", 32'(fse_flag), 1);
        do_read(); chk("R4 word delay0", 32'(rd_data), 32'h69);
        pulse_fse_clr();

        // R6: overfill
        delay_sel = 2'd1;
        run_words(1, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}, 1);
        do_read(); chk("R6 first kept", 32'(rd_data), 32'h11);
        do_read(); do_read();
        do_read(); chk("R6 fourth kept", 32'(rd_data), 32'h44);
        chk("R6 extra words dropped", 32'(rx_ready), 0);

        // R7 R9 R8: empty read, interrupt, clear
        do_read();
        chk("R7 empty read zero", 32'(rd_data), 0);
        chk("R7 unf set", 32'(unf_flag), 1);
        chk("R9 irq masked", 32'(irq_n), 1);
        @(negedge clk); unf_irq_en = 1'b1;
        @(negedge clk); chk("R9 irq asserted", 32'(irq_n), 0);
        pulse_unf_clr();
        chk("R8 unf cleared", 32'(unf_flag), 0);
        chk("R9 irq released", 32'(irq_n), 1);
        @(negedge clk); rd_en = 1'b1; unf_clr = 1'b1;
        @(negedge clk); rd_en = 1'b0; unf_clr = 1'b0;
        chk("R8 set wins", 32'(unf_flag), 1);
        pulse_unf_clr();
        run_words(1, '{8'hE7}, 0);
        do_read(); chk("R7 buffer intact after underflow", 32'(rd_data), 32'hE7);

        // R10: hold mid-frame with a buffered word and flags set
        run_words(1, '{8'h42}, 0);
        do_read(); do_read();
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        run_words(1, '{8'h24}, 0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b1);
        send_bit(1'b0, 1'b1);
        @(negedge clk); rx_hold = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 buffer flushed", 32'(rx_ready), 0);
        chk("R10 unf kept", 32'(unf_flag), 1);
        chk("R10 fse kept", 32'(fse_flag), 1);
        rx_hold = 1'b0;
        run_words(1, '{8'hB4}, 0);
        do_read(); chk("R10 fresh frame after hold", 32'(rd_data), 32'hB4);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule